// File: doc/BRIEF.md
# Five-into-four sample repacker

This block maps groups of five 12-bit converter samples onto four 16-bit link container words, and maps them back on the receive side. A link whose container is 16 bits wide then carries 64 bits per five samples. That is an effective 12.8 bits per sample, so lane-rate budgeting uses 12.8 in place of 16. With all other link parameters equal, the lane rate can drop by 20%. The transmit and receive halves must use the same fixed mapping, which is set at compile time.

The transmit half takes a whole group through a valid/ready handshake and emits its four words on consecutive cycles. Word 0 leaves in the same cycle the group is accepted. The receive half counts valid words. Once it has the fourth word, it presents all five samples with a one-cycle valid pulse. Scrambling, line coding, lane striping and link start-up are handled elsewhere.

Top module: `five_four_repack`

## Requirements
- R1: Within the 64-bit group, sample k (k = 0..4, taken from `tx_samples_i[59-12k -: 12]`) occupies bits `[63-12k -: 12]`, and bits 3:0 are zero. Word n (n = 0..3) is group bits `[63-16n -: 16]`.
- R2: In a cycle where `tx_valid_i` and `tx_ready_o` are both high, the group is accepted, `tx_word_valid_o` is high and `tx_word_o` carries word 0 of that group.
- R3: Words 1, 2 and 3 follow on `tx_word_o` in the next three cycles, with `tx_word_valid_o` high.
- R4: `tx_ready_o` is low while words 1 to 3 are being emitted. Changes on `tx_valid_i` and `tx_samples_i` in those cycles do not affect the words sent.
- R5: `tx_ready_o` is high in the cycle after word 3, so groups can stream back to back at four cycles per group. When the transmitter is idle and `tx_valid_i` is low, `tx_word_valid_o` is low.
- R6: `rx_valid_o` goes high for exactly one cycle, in the cycle after the clock edge that captures the fourth valid word. `rx_samples_o` then holds the five recovered samples (sample 0 in bits 59:48) and keeps them until the next pulse.
- R7: Bits 3:0 of the fourth received word have no effect on `rx_samples_o`.
- R8: Cycles with `rx_word_valid_i` low do not advance the receive word count. Gaps between words are allowed.
- R9: While `rst_ni` is low, `tx_ready_o` is 1, `tx_word_valid_o` is 0, `rx_valid_o` is 0 and `rx_samples_o` is 0. Both word counters restart from word 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_valid_i | input | 1 | Sample group offered |
| tx_ready_o | output | 1 | Transmitter can take a group |
| tx_samples_i | input | 60 | Five 12-bit samples, sample 0 in the top bits |
| tx_word_valid_o | output | 1 | Container word valid |
| tx_word_o | output | 16 | Container word out |
| rx_word_valid_i | input | 1 | Container word in is valid |
| rx_word_i | input | 16 | Container word in |
| rx_valid_o | output | 1 | Recovered group pulse |
| rx_samples_o | output | 60 | Recovered five samples |

## Verification
Word 0 of a group is combinational from the accepted input, so the bench checks it in the accept cycle itself. Words 1 to 3 each come one register later, and the bench samples them in the three following cycles, just after the falling edge. The receive pulse comes from one register stage behind the edge that captures the last word. The bench therefore checks it in the cycle after the last word is driven, and checks it again one cycle later to confirm it has dropped.

// File: rtl/repack_pkg.sv
package repack_pkg;
  localparam int unsigned SMP_W_DEF  = 12;
  localparam int unsigned N_SMP_DEF  = 5;
  localparam int unsigned WORD_W_DEF = 16;
  localparam int unsigned N_WORD_DEF = 4;

  typedef enum logic {
    TX_IDLE = 1'b0,
    TX_EMIT = 1'b1
  } tx_state_e;
endpackage

// File: rtl/repack_tx.sv
module repack_tx
  import repack_pkg::*;
#(
  parameter int unsigned SMP_W  = SMP_W_DEF,
  parameter int unsigned N_SMP  = N_SMP_DEF,
  parameter int unsigned WORD_W = WORD_W_DEF,
  parameter int unsigned N_WORD = N_WORD_DEF
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   valid_i,
  output logic                   ready_o,
  input  logic [SMP_W*N_SMP-1:0] samples_i,
  output logic                   word_valid_o,
  output logic [WORD_W-1:0]      word_o
);
  localparam int unsigned DATA_W = SMP_W * N_SMP;
  localparam int unsigned GRP_W  = WORD_W * N_WORD;
  localparam int unsigned PAD_W  = GRP_W - DATA_W;
  localparam int unsigned CNT_W  = $clog2(N_WORD);

  tx_state_e          state_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [GRP_W-1:0]   grp_q;
  logic [GRP_W-1:0]   grp_in;
  logic [WORD_W-1:0]  in_words  [N_WORD];
  logic [WORD_W-1:0]  reg_words [N_WORD];
  logic               accept;

  assign grp_in = {samples_i, {PAD_W{1'b0}}};

  for (genvar g = 0; g < N_WORD; g++) begin : g_slice
    assign in_words[g]  = grp_in[GRP_W-1-g*WORD_W -: WORD_W];
    assign reg_words[g] = grp_q[GRP_W-1-g*WORD_W -: WORD_W];
  end

  assign ready_o      = (state_q == TX_IDLE);
  assign accept       = valid_i && ready_o;
  assign word_valid_o = accept || (state_q == TX_EMIT);
  // word 0 leaves straight from the input on accept
  assign word_o       = (state_q == TX_EMIT) ? reg_words[cnt_q] : in_words[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TX_IDLE;
      cnt_q   <= '0;
      grp_q   <= '0;
    end else if (accept) begin
      state_q <= TX_EMIT;
      cnt_q   <= CNT_W'(1);
      grp_q   <= grp_in;
    end else if (state_q == TX_EMIT) begin
      if (cnt_q == CNT_W'(N_WORD-1)) state_q <= TX_IDLE;
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/repack_rx.sv
module repack_rx
  import repack_pkg::*;
#(
  parameter int unsigned SMP_W  = SMP_W_DEF,
  parameter int unsigned N_SMP  = N_SMP_DEF,
  parameter int unsigned WORD_W = WORD_W_DEF,
  parameter int unsigned N_WORD = N_WORD_DEF
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   word_valid_i,
  input  logic [WORD_W-1:0]      word_i,
  output logic                   valid_o,
  output logic [SMP_W*N_SMP-1:0] samples_o
);
  localparam int unsigned DATA_W = SMP_W * N_SMP;
  localparam int unsigned GRP_W  = WORD_W * N_WORD;
  localparam int unsigned PAD_W  = GRP_W - DATA_W;
  localparam int unsigned CNT_W  = $clog2(N_WORD);

  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] buf_q [N_WORD-1];
  logic [DATA_W-1:0] data_asm;
  logic              last;

  for (genvar g = 0; g < N_WORD-1; g++) begin : g_asm
    assign data_asm[DATA_W-1-g*WORD_W -: WORD_W] = buf_q[g];
  end
  // pad bits of the final word are dropped here
  assign data_asm[WORD_W-PAD_W-1:0] = word_i[WORD_W-1:PAD_W];

  assign last = word_valid_i && (cnt_q == CNT_W'(N_WORD-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int i = 0; i < N_WORD-1; i++) buf_q[i] <= '0;
    end else if (word_valid_i) begin
      cnt_q <= cnt_q + CNT_W'(1);
      for (int i = 0; i < N_WORD-1; i++)
        if (cnt_q == CNT_W'(i)) buf_q[i] <= word_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      samples_o <= '0;
    end else begin
      valid_o <= last;
      if (last) samples_o <= data_asm;
    end
  end
endmodule

// File: rtl/five_four_repack.sv
module five_four_repack
  import repack_pkg::*;
#(
  parameter int unsigned SMP_W  = SMP_W_DEF,
  parameter int unsigned N_SMP  = N_SMP_DEF,
  parameter int unsigned WORD_W = WORD_W_DEF,
  parameter int unsigned N_WORD = N_WORD_DEF
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   tx_valid_i,
  output logic                   tx_ready_o,
  input  logic [SMP_W*N_SMP-1:0] tx_samples_i,
  output logic                   tx_word_valid_o,
  output logic [WORD_W-1:0]      tx_word_o,
  input  logic                   rx_word_valid_i,
  input  logic [WORD_W-1:0]      rx_word_i,
  output logic                   rx_valid_o,
  output logic [SMP_W*N_SMP-1:0] rx_samples_o
);
  localparam int unsigned DATA_W = SMP_W * N_SMP;

  repack_tx #(
    .SMP_W(SMP_W), .N_SMP(N_SMP), .WORD_W(WORD_W), .N_WORD(N_WORD)
  ) u_tx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .valid_i      (tx_valid_i),
    .ready_o      (tx_ready_o),
    .samples_i    (tx_samples_i),
    .word_valid_o (tx_word_valid_o),
    .word_o       (tx_word_o)
  );

  repack_rx #(
    .SMP_W(SMP_W), .N_SMP(N_SMP), .WORD_W(WORD_W), .N_WORD(N_WORD)
  ) u_rx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .word_valid_i (rx_word_valid_i),
    .word_i       (rx_word_i),
    .valid_o      (rx_valid_o),
    .samples_o    (rx_samples_o)
  );
endmodule

// File: rtl/five_four_repack_chk.sv
module five_four_repack_chk #(
  parameter int unsigned DATA_W = 60,
  parameter int unsigned WORD_W = 16,
  parameter int unsigned N_WORD = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tx_valid_i,
  input logic              tx_ready_o,
  input logic [DATA_W-1:0] tx_samples_i,
  input logic              tx_word_valid_o,
  input logic [WORD_W-1:0] tx_word_o,
  input logic              rx_word_valid_i,
  input logic [WORD_W-1:0] rx_word_i,
  input logic              rx_valid_o,
  input logic [DATA_W-1:0] rx_samples_o
);
  localparam int unsigned PAD_W = WORD_W * N_WORD - DATA_W;
  localparam int unsigned CNT_W = $clog2(N_WORD);

  logic [CNT_W-1:0] wcnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              wcnt_q <= '0;
    else if (tx_word_valid_o) wcnt_q <= wcnt_q + CNT_W'(1);
  end

  a_r2_first_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_i && tx_ready_o) |->
      (tx_word_valid_o && tx_word_o == tx_samples_i[DATA_W-1 -: WORD_W]));

  a_r3_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_ready_o |-> tx_word_valid_o);

  a_r4_no_ready_mid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_word_valid_o && wcnt_q != '0) |-> !tx_ready_o);

  a_r1_pad_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_word_valid_o && wcnt_q == CNT_W'(N_WORD-1)) |-> (tx_word_o[PAD_W-1:0] == '0));

  a_r5_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_ready_o && !tx_valid_i) |-> !tx_word_valid_o);

  a_r6_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);

  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_valid_o |-> $stable(rx_samples_o));

  a_r8_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_word_valid_i |=> !rx_valid_o);
endmodule

bind five_four_repack five_four_repack_chk #(
  .DATA_W(DATA_W), .WORD_W(WORD_W), .N_WORD(N_WORD)
) u_chk (.*);

// File: tb/five_four_repack_test.sv
module five_four_repack_test;
  localparam int NV = 6;
  localparam logic [59:0] VEC_S [NV] = '{
    60'h123_456_789_ABC_DEF, 60'hFFF_FFF_FFF_FFF_FFF, 60'h000_000_000_000_000,
    60'h800_001_800_001_800, 60'hA5A_5A5_A5A_5A5_A5A, 60'hFFF_000_FFF_000_FFF};
  localparam logic [63:0] VEC_G [NV] = '{
    64'h1234_5678_9ABC_DEF0, 64'hFFFF_FFFF_FFFF_FFF0, 64'h0000_0000_0000_0000,
    64'h8000_0180_0001_8000, 64'hA5A5_A5A5_A5A5_A5A0, 64'hFFF0_00FF_F000_FFF0};

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tx_valid_i = 1'b0;
  logic        tx_ready_o;
  logic [59:0] tx_samples_i = '0;
  logic        tx_word_valid_o;
  logic [15:0] tx_word_o;
  logic        rx_word_valid_i = 1'b0;
  logic [15:0] rx_word_i = '0;
  logic        rx_valid_o;
  logic [59:0] rx_samples_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  five_four_repack uut (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] wsel(input logic [63:0] g, input int n);
    return g[63-16*n -: 16];
  endfunction

  task automatic send_tx(input logic [59:0] s, input logic [63:0] g);
    @(negedge clk_i);
    tx_valid_i = 1'b1; tx_samples_i = s;
    #1;
    chk(tx_ready_o, "R2 ready", 64'(tx_ready_o), 64'd1);
    chk(tx_word_valid_o && tx_word_o == wsel(g, 0), "R2 word0", 64'(tx_word_o), 64'(wsel(g, 0)));
    for (int n = 1; n < 4; n++) begin
      @(negedge clk_i);
      tx_valid_i = 1'b1; tx_samples_i = ~s;  // R4: must be ignored
      #1;
      chk(!tx_ready_o, "R4 ready low", 64'(tx_ready_o), 64'd0);
      chk(tx_word_valid_o && tx_word_o == wsel(g, n), "R3 word", 64'(tx_word_o), 64'(wsel(g, n)));
    end
  endtask

  task automatic idle_chk();
    @(negedge clk_i);
    tx_valid_i = 1'b0;
    #1;
    chk(tx_ready_o && !tx_word_valid_o, "R5 idle", {62'd0, tx_ready_o, tx_word_valid_o}, 64'd2);
  endtask

  task automatic feed_rx(input logic [63:0] g, input logic [59:0] s, input bit gaps, input logic [3:0] pad);
    for (int n = 0; n < 4; n++) begin
      @(negedge clk_i);
      rx_word_valid_i = 1'b1;
      rx_word_i = (n == 3) ? {wsel(g, 3)[15:4], pad} : wsel(g, n);
      #1;
      chk(!rx_valid_o, "R8 no early pulse", 64'(rx_valid_o), 64'd0);
      if (gaps && n < 3) begin
        @(negedge clk_i);
        rx_word_valid_i = 1'b0; rx_word_i = 16'hDEAD;
        #1;
        chk(!rx_valid_o, "R8 gap", 64'(rx_valid_o), 64'd0);
      end
    end
    @(negedge clk_i);
    rx_word_valid_i = 1'b0; rx_word_i = 16'hBEEF;
    #1;
    chk(rx_valid_o, "R6 pulse", 64'(rx_valid_o), 64'd1);
    chk(rx_samples_o == s, "R6 R7 samples", 64'(rx_samples_o), 64'(s));
    @(negedge clk_i);
    #1;
    chk(!rx_valid_o && rx_samples_o == s, "R6 pulse end", 64'(rx_valid_o), 64'd0);
  endtask

  initial begin
    #1;
    chk(tx_ready_o && !tx_word_valid_o, "R9 tx reset", {62'd0, tx_ready_o, tx_word_valid_o}, 64'd2);
    chk(!rx_valid_o && rx_samples_o == '0, "R9 rx reset", 64'(rx_samples_o), 64'd0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 layout via table
    for (int i = 0; i < NV; i++) begin
      send_tx(VEC_S[i], VEC_G[i]);
      idle_chk();
      feed_rx(VEC_G[i], VEC_S[i], (i % 2) == 1, 4'(i * 3 + 5));
    end

    // R5 back to back
    send_tx(VEC_S[0], VEC_G[0]);
    send_tx(VEC_S[3], VEC_G[3]);
    idle_chk();

    // R9 mid-group reset on both halves
    @(negedge clk_i);
    tx_valid_i = 1'b1; tx_samples_i = VEC_S[4];
    rx_word_valid_i = 1'b1; rx_word_i = 16'h1111;
    @(negedge clk_i);
    tx_valid_i = 1'b0;
    rx_word_i = 16'h2222;
    @(negedge clk_i);
    rx_word_valid_i = 1'b0;
    rst_ni = 1'b0;
    #1;
    chk(tx_ready_o && !tx_word_valid_o, "R9 tx mid reset", {62'd0, tx_ready_o, tx_word_valid_o}, 64'd2);
    chk(!rx_valid_o && rx_samples_o == '0, "R9 rx mid reset", 64'(rx_samples_o), 64'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    feed_rx(VEC_G[4], VEC_S[4], 1'b0, 4'hF);
    send_tx(VEC_S[5], VEC_G[5]);
    idle_chk();

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule